// File: doc/BRIEF.md
# Keyed Windowed Deadman Timer

This peripheral counts system clock cycles while its enable bit is set. Software keeps it from expiring with a clear that has two ordered steps. First it writes an arming key to the pre-clear register. Then, once the status register shows that the clear window has opened, it writes a confirmation key to the clear register. A correct confirmation zeroes the counter.

The window opens when the count comes within the programmed window interval of the count limit. The block treats any of the following as a fault and records it in a sticky flag: a wrong arming key, a confirmation key with a wrong value, a confirmation with no arming step before it, or a confirmation sent while the window is closed. Each fault raises the timeout event at once. If the counter reaches the limit without a valid clear, the block raises the event and sends one reset request pulse. It also sets a sticky reset-cause flag that software can read and clear.

Registers are reached through a plain single-cycle read/write bus. Read data is combinational from the address. The timeout period in seconds is the count limit divided by the clock rate.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset, every register reads zero except count limit (0x60) and window interval (0x70), which read their parameter defaults. Count limit and window interval read back what was written. The control register (0x00) keeps only bit 15 and reads every other bit as zero.
- R2: While control bit 15 is 1, the counter (read at 0x40) advances by one on each clock. While the bit is 0, the counter holds its value.
- R3: Status bit 0 (0x30) is 1 exactly when the timer is enabled and counter + window interval >= count limit.
- R4: A pre-clear write (0x10) with bits 15:8 equal to 0x40, followed by a clear write (0x20) of 0x08 while the window is open, zeroes the counter on that write's clock edge. It leaves no fault flag set.
- R5: A pre-clear write whose bits 15:8 are not 0x40 sets status bit 7 and the sticky event flag (status bit 5, also driven on event_o).
- R6: A clear write that has a wrong value, no valid pre-clear before it, or a closed window sets status bit 6 and the event flag. The counter keeps counting.
- R7: When the counter reaches the count limit, rst_req_o goes high for exactly one cycle on the next edge. The event flag sets on that same edge, and the counter holds at the limit.
- R8: Expiry sets bit 5 of the reset-cause register (0x50). Writing a 1 to that bit clears it.
- R9: In the cycle right after the enable bit goes from 1 to 0, writes are ignored and reads return zero.
- R10: Key writes to 0x10 and 0x20 are ignored while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| event_o | output | 1 | Sticky timeout/fault event |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest case to reach from the ports is a confirmation key that arrives exactly at the cycle the window opens, together with the one-cycle lockout after disable. Both depend on exact cycle placement. The bench therefore makes every write consume exactly one clock edge and every read consume none. This lets it count edges from the enable write and place the key in the first open cycle, right after a read showing the window is still closed one cycle earlier. It also issues a read and a write inside the single lockout cycle before any clock edge passes.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [AW-1:0] OFS_PRE   = 8'h10;
  localparam logic [AW-1:0] OFS_CLR   = 8'h20;
  localparam logic [AW-1:0] OFS_STAT  = 8'h30;
  localparam logic [AW-1:0] OFS_CNT   = 8'h40;
  localparam logic [AW-1:0] OFS_CAUSE = 8'h50;
  localparam logic [AW-1:0] OFS_LIM   = 8'h60;
  localparam logic [AW-1:0] OFS_WIN   = 8'h70;

  localparam logic [7:0] ARM_KEY  = 8'h40;
  localparam logic [7:0] CONF_KEY = 8'h08;

  localparam int unsigned ON_BIT    = 15;
  localparam int unsigned CAUSE_BIT = 5;

  typedef struct packed {
    logic       bad1;
    logic       bad2;
    logic       evt;
    logic       win;
  } stat_t;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pre_wr_i,
  input  logic       clr_wr_i,
  input  logic [7:0] key_i,
  input  logic       win_open_i,
  output logic       clr_ok_o,
  output logic       err_o,
  output logic       bad1_o,
  output logic       bad2_o
);
  logic armed_q, bad1_q, bad2_q;
  logic pre_good, pre_bad, clr_bad;

  assign pre_good = pre_wr_i & (key_i == ARM_KEY);
  assign pre_bad  = pre_wr_i & (key_i != ARM_KEY);
  assign clr_ok_o = clr_wr_i & (key_i == CONF_KEY) & armed_q & win_open_i;
  assign clr_bad  = clr_wr_i & ~clr_ok_o;
  assign err_o    = pre_bad | clr_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      bad1_q  <= 1'b0;
      bad2_q  <= 1'b0;
    end else begin
      if (pre_good)                 armed_q <= 1'b1;
      else if (pre_bad || clr_wr_i) armed_q <= 1'b0;
      if (pre_bad) bad1_q <= 1'b1;
      if (clr_bad) bad2_q <= 1'b1;
    end
  end

  assign bad1_o = bad1_q;
  assign bad2_o = bad2_q;
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             clr_ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             win_open_o,
  output logic             expire_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q, req_q, at_lim;
  logic [CNT_W:0]   reach;

  assign at_lim     = cnt_q >= limit_i;
  assign expire_o   = on_i & at_lim & ~fired_q;
  assign reach      = {1'b0, cnt_q} + {1'b0, win_i};
  assign win_open_o = on_i & (reach >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= expire_o;
      if (expire_o) fired_q <= 1'b1;
      if (clr_ok_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (on_i && !at_lim) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/kwdt_regfile.sv
module kwdt_regfile
  import kwdt_pkg::*;
#(
  parameter int unsigned      CNT_W     = 32,
  parameter logic [CNT_W-1:0] DEF_LIMIT = '1,
  parameter logic [CNT_W-1:0] DEF_WIN   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  stat_t            stat_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             evt_set_i,
  input  logic             expire_i,
  output logic             on_o,
  output logic [CNT_W-1:0] limit_o,
  output logic [CNT_W-1:0] win_o,
  output logic             pre_wr_o,
  output logic             clr_wr_o,
  output logic [7:0]       key_o,
  output logic             event_o
);
  logic             on_q, on_d1_q, lock, wr;
  logic [CNT_W-1:0] lim_q, win_q;
  logic             evt_q, cause_q;

  assign lock = on_d1_q & ~on_q;
  assign wr   = req_i & we_i & ~lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q    <= 1'b0;
      on_d1_q <= 1'b0;
      lim_q   <= DEF_LIMIT;
      win_q   <= DEF_WIN;
      evt_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      on_d1_q <= on_q;
      if (wr && addr_i == OFS_CTRL) on_q  <= wdata_i[ON_BIT];
      if (wr && addr_i == OFS_LIM)  lim_q <= wdata_i[CNT_W-1:0];
      if (wr && addr_i == OFS_WIN)  win_q <= wdata_i[CNT_W-1:0];
      if (evt_set_i) evt_q <= 1'b1;
      if (expire_i) cause_q <= 1'b1;
      else if (wr && addr_i == OFS_CAUSE && wdata_i[CAUSE_BIT]) cause_q <= 1'b0;
    end
  end

  // key writes only count while the timer runs
  assign pre_wr_o = wr & on_q & (addr_i == OFS_PRE);
  assign clr_wr_o = wr & on_q & (addr_i == OFS_CLR);
  assign key_o    = (addr_i == OFS_PRE) ? wdata_i[15:8] : wdata_i[7:0];

  always_comb begin
    rdata_o = '0;
    if (!lock) begin
      unique case (addr_i)
        OFS_CTRL:  rdata_o[ON_BIT] = on_q;
        OFS_STAT:  rdata_o = {24'd0, stat_i.bad1, stat_i.bad2, evt_q, 4'd0, stat_i.win};
        OFS_CNT:   rdata_o = DW'(cnt_i);
        OFS_CAUSE: rdata_o[CAUSE_BIT] = cause_q;
        OFS_LIM:   rdata_o = DW'(lim_q);
        OFS_WIN:   rdata_o = DW'(win_q);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign on_o    = on_q;
  assign limit_o = lim_q;
  assign win_o   = win_q;
  assign event_o = evt_q;
endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned      CNT_W     = 32,
  parameter logic [CNT_W-1:0] DEF_LIMIT = CNT_W'(1000),
  parameter logic [CNT_W-1:0] DEF_WIN   = CNT_W'(100)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          event_o,
  output logic          rst_req_o
);
  logic             on_w, pre_wr_w, clr_wr_w, clr_ok_w, err_w;
  logic             win_open_w, expire_w, bad1_w, bad2_w;
  logic [CNT_W-1:0] cnt_w, lim_w, win_w;
  logic [7:0]       key_w;
  stat_t            stat_w;

  assign stat_w = '{bad1: bad1_w, bad2: bad2_w, evt: 1'b0, win: win_open_w};

  kwdt_regfile #(
    .CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT), .DEF_WIN(DEF_WIN)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .stat_i(stat_w), .cnt_i(cnt_w), .evt_set_i(err_w | expire_w),
    .expire_i(expire_w), .on_o(on_w), .limit_o(lim_w), .win_o(win_w),
    .pre_wr_o(pre_wr_w), .clr_wr_o(clr_wr_w), .key_o(key_w), .event_o
  );

  kwdt_keyseq u_keys (
    .clk_i, .rst_ni, .pre_wr_i(pre_wr_w), .clr_wr_i(clr_wr_w), .key_i(key_w),
    .win_open_i(win_open_w), .clr_ok_o(clr_ok_w), .err_o(err_w),
    .bad1_o(bad1_w), .bad2_o(bad2_w)
  );

  kwdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .on_i(on_w), .limit_i(lim_w), .win_i(win_w),
    .clr_ok_i(clr_ok_w), .cnt_o(cnt_w), .win_open_o(win_open_w),
    .expire_o(expire_w), .rst_req_o
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req,
  input logic             evt,
  input logic [31:0]      rdata,
  input logic             on,
  input logic             clr_ok,
  input logic [CNT_W-1:0] cnt
);
  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> !rst_req);
  assert_req_evt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |-> evt);
  assert_evt_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> evt);
  assert_hold_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |=> $stable(cnt));
  assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ok |=> cnt == '0);
  assert_lock_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(on) |-> rdata == 32'd0);
endmodule

bind keyed_window_wdt kwdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rst_req(rst_req_o), .evt(event_o),
  .rdata(rdata_o), .on(on_w), .clr_ok(clr_ok_w), .cnt(cnt_w)
);

// File: tb/keyed_window_wdt_tb_top.sv
`timescale 1ns/100ps
module keyed_window_wdt_tb_top;
  import kwdt_pkg::*;

  localparam int LIM = 20;
  localparam int WIN = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic event_w, rst_req_w;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  keyed_window_wdt #(.CNT_W(32), .DEF_LIMIT(32'd48), .DEF_WIN(32'd6)) dut_i (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_o(event_w), .rst_req_o(rst_req_w)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0, OFS_CTRL,  32'h0,        32'h0},
    '{1'b0, OFS_LIM,   32'h0,        32'd48},
    '{1'b0, OFS_WIN,   32'h0,        32'd6},
    '{1'b0, OFS_STAT,  32'h0,        32'h0},
    '{1'b0, OFS_CNT,   32'h0,        32'h0},
    '{1'b0, OFS_CAUSE, 32'h0,        32'h0},
    '{1'b1, OFS_LIM,   32'd20,       32'h0},
    '{1'b0, OFS_LIM,   32'h0,        32'd20},
    '{1'b1, OFS_WIN,   32'd5,        32'h0},
    '{1'b0, OFS_WIN,   32'h0,        32'd5},
    '{1'b1, OFS_CTRL,  32'h0001_8123, 32'h0},
    '{1'b0, OFS_CTRL,  32'h0,        32'h0000_8000},
    '{1'b1, OFS_CTRL,  32'h0,        32'h0},
    '{1'b0, OFS_CTRL,  32'h0,        32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one write = exactly one clock edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // one read = no clock edge
  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_run();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    bus_wr(OFS_LIM, LIM);
    bus_wr(OFS_WIN, WIN);
    bus_wr(OFS_CTRL, 32'h8000);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    check("R7 reset rst_req", {31'd0, rst_req_w}, 32'd0);
    check("R5 reset event", {31'd0, event_w}, 32'd0);

    // R1: register table walk
    foreach (VECS[i]) begin
      if (VECS[i].wr) bus_wr(VECS[i].a, VECS[i].d);
      else begin
        bus_rd(VECS[i].a, v);
        check($sformatf("R1 vector %0d", i), v, VECS[i].e);
      end
    end

    // R4 / R3: correct sequence, key at first open cycle
    start_run();
    bus_wr(OFS_PRE, 32'h4000);
    idle(13);
    rd_chk("R3 window closed at 14", OFS_STAT, 32'h0);
    idle(1);
    rd_chk("R3 window open at 15", OFS_STAT, 32'h1);
    bus_wr(OFS_CLR, 32'h08);
    rd_chk("R4 counter zeroed", OFS_CNT, 32'd0);
    rd_chk("R4 no flags", OFS_STAT, 32'h0);
    idle(4);
    rd_chk("R2 counting resumes", OFS_CNT, 32'd4);

    // R6: armed but window closed
    start_run();
    bus_wr(OFS_PRE, 32'h4000);
    bus_wr(OFS_CLR, 32'h08);
    rd_chk("R6 early clear flags", OFS_STAT, 32'h60);
    rd_chk("R6 counter not cleared", OFS_CNT, 32'd2);
    check("R6 event_o", {31'd0, event_w}, 32'd1);

    // R5: bad arming key
    start_run();
    bus_wr(OFS_PRE, 32'h4100);
    rd_chk("R5 bad first key", OFS_STAT, 32'hA0);

    // R6: no arming, window open
    start_run();
    idle(15);
    bus_wr(OFS_CLR, 32'h08);
    rd_chk("R6 unarmed clear", OFS_STAT, 32'h61);

    // R6: armed, window open, wrong value
    start_run();
    bus_wr(OFS_PRE, 32'h4000);
    idle(14);
    bus_wr(OFS_CLR, 32'h09);
    rd_chk("R6 wrong second key", OFS_STAT, 32'h61);
    rd_chk("R6 counter kept", OFS_CNT, 32'd16);

    // R7 / R8: expiry
    start_run();
    idle(LIM);
    check("R7 no request at limit", {31'd0, rst_req_w}, 32'd0);
    check("R7 no event at limit", {31'd0, event_w}, 32'd0);
    idle(1);
    check("R7 request pulse", {31'd0, rst_req_w}, 32'd1);
    rd_chk("R7 status event", OFS_STAT, 32'h21);
    idle(1);
    check("R7 request ends", {31'd0, rst_req_w}, 32'd0);
    idle(3);
    rd_chk("R7 counter holds", OFS_CNT, LIM);
    rd_chk("R8 cause set", OFS_CAUSE, 32'h20);
    bus_wr(OFS_CAUSE, 32'h20);
    rd_chk("R8 cause cleared", OFS_CAUSE, 32'h0);

    // R9 / R2: lockout after disable
    start_run();
    idle(3);
    bus_wr(OFS_CTRL, 32'h0);
    rd_chk("R9 read blocked", OFS_LIM, 32'd0);
    bus_wr(OFS_LIM, 32'd7);
    rd_chk("R9 write ignored", OFS_LIM, LIM);
    rd_chk("R2 stopped count", OFS_CNT, 32'd4);
    idle(5);
    rd_chk("R2 count holds off", OFS_CNT, 32'd4);

    // R10: keys while disabled
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    bus_wr(OFS_PRE, 32'h4100);
    bus_wr(OFS_CLR, 32'h09);
    rd_chk("R10 keys ignored off", OFS_STAT, 32'h0);
    check("R10 event stays low", {31'd0, event_w}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule